// File: doc/BRIEF.md
# Test Parameter Register Bank with Two-Stage Read Path

This block sits behind a simple word-addressed register bridge and holds the parameters that a storage test system needs for one operation: a 48-bit starting block address, a 48-bit transfer length (both counted in 512-byte blocks), a test pattern selector and a 32-bit timeout. Writing an operation code to the command register launches the operation through a one-cycle request pulse toward the storage controller. Sixteen dwords of a custom submission entry are also held here, and the bank forwards the controller's status flags, four completion dwords and two external memories to the read side.

The word address is split into six regions by its upper bits. Reads pass through two registered stages: the first selects a word inside a region (or takes the one-cycle read data of an external memory), the second selects among regions. Read-valid therefore follows a read request by exactly two clocks. The bridge holds the address until read-valid. A separate helper widens per-dword write enables of the 256-bit memory data side into byte enables.

Top module: `tst_regbank`

## Requirements
- R1: After reset, `cmd_req`, `reg_rd_valid`, `reg_rd_data`, `start_lba`, `xfer_len`, `patt_sel`, `timeout_val` and all `cq_dwords` are zero.
- R2: A write at byte offset 0x00 / 0x04 loads bits 31:0 / 47:32 of `start_lba`, and 0x08 / 0x0C loads bits 31:0 / 47:32 of `xfer_len`; high registers take `reg_wr_data[15:0]`.
- R3: A write at byte offset 0x10 with `reg_wr_data[2:0]` in {000 identify, 001 shutdown, 010 write, 011 read, 100 SMART, 110 flush} drives `cmd_req` high for exactly the one cycle after the write cycle, with `cmd_code` equal to that value.
- R4: A write at 0x10 with code 101 or 111 produces no `cmd_req` and leaves `cmd_code` unchanged.
- R5: A write at 0x14 loads `patt_sel` from bits 2:0; a write at 0x20 loads the whole of `timeout_val`.
- R6: A read at 0x100 returns bit 0 = `sts_busy`, bit 1 = `sts_error`, bit 2 = `sts_verify_fail`, all other bits zero.
- R7: Writes at 0x200 + 4*k (k = 0..15) load dword k of `cq_dwords` (bits 32k+31:32k).
- R8: A read at 0x300 + 4*k (k = 0..3) returns dword k of `cpl_dwords`; other offsets of that region read zero.
- R9: `reg_rd_valid` rises exactly two clocks after the cycle in which `reg_rd_req` is sampled, and `reg_rd_data` carries the value selected by the address of that request.
- R10: Reads at 0x2000-0x3FFF and 0x4000-0x5FFF assert `idm_rd_en` or `cm_rd_en` with `mem_addr` equal to the word address modulo 2048 and return the memory's data, which arrives one clock after the enable; writes at 0x4000-0x5FFF assert `cm_wr_en` with `cm_wr_data`.
- R11: `reg_wr_be` has no effect: every write updates the full 32-bit target, even with all byte enables zero.
- R12: Reads of write-only regions (0x000-0x0FF, 0x200-0x2FF) and of unmapped addresses return zero; writes to 0x100-0x1FF, 0x300-0x3FF and 0x2000-0x3FFF change no output register and raise no request.
- R13: `dp_byte_en[4i+3:4i]` equals four copies of `dp_dw_en[i]` for every dword lane i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_req | input | 1 | Register read request |
| reg_addr | input | 13 | Word address (byte address / 4) |
| reg_wr_data | input | 32 | Write data |
| reg_wr_be | input | 4 | Write byte enables (ignored) |
| reg_rd_valid | output | 1 | Read data valid |
| reg_rd_data | output | 32 | Read data |
| cmd_req | output | 1 | One-cycle operation request |
| cmd_code | output | 3 | Operation code of the last accepted request |
| start_lba | output | 48 | Starting block address |
| xfer_len | output | 48 | Transfer length in blocks |
| patt_sel | output | 3 | Test pattern selector |
| timeout_val | output | 32 | Controller timeout setting |
| sts_busy | input | 1 | Controller busy |
| sts_error | input | 1 | Controller error |
| sts_verify_fail | input | 1 | Data verification failure |
| cq_dwords | output | 512 | Sixteen custom submission dwords |
| cpl_dwords | input | 128 | Four completion dwords |
| mem_addr | output | 11 | Word address to both external memories |
| idm_rd_en | output | 1 | Identify memory read enable |
| idm_rd_data | input | 32 | Identify memory read data (one-cycle latency) |
| cm_rd_en | output | 1 | Custom memory read enable |
| cm_wr_en | output | 1 | Custom memory write enable |
| cm_wr_data | output | 32 | Custom memory write data |
| cm_rd_data | input | 32 | Custom memory read data (one-cycle latency) |
| dp_dw_en | input | 8 | Dword write enables of the 256-bit data side |
| dp_byte_en | output | 32 | Expanded byte enables |

## Verification
A command launch and a read return can land in the same cycle: a status read is requested, and in the very next cycle the command register is written, so the `cmd_req` pulse and `reg_rd_valid` appear together. The bench judges that the pulse has the written code and that the read returns the status captured at request time, undisturbed by the address having moved on to the command register. A second overlap puts a custom-memory write right after a custom-memory read request, and the returned word must be the old contents.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  typedef enum logic [2:0] {
    RG_CTRL = 3'd0,
    RG_STAT = 3'd1,
    RG_CQ   = 3'd2,
    RG_CPL  = 3'd3,
    RG_IDEN = 3'd4,
    RG_CMEM = 3'd5,
    RG_NONE = 3'd6
  } region_e;

  // word offsets inside the control region
  localparam logic [5:0] W_LBA_LO  = 6'd0;
  localparam logic [5:0] W_LBA_HI  = 6'd1;
  localparam logic [5:0] W_LEN_LO  = 6'd2;
  localparam logic [5:0] W_LEN_HI  = 6'd3;
  localparam logic [5:0] W_CMD     = 6'd4;
  localparam logic [5:0] W_PATT    = 6'd5;
  localparam logic [5:0] W_TIMEOUT = 6'd8;

  function automatic logic cmd_is_legal(input logic [2:0] code);
    return !(code == 3'b101 || code == 3'b111);
  endfunction

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);
  localparam int MEM_AW = ADDR_W - 2;

  always_comb begin
    region = RG_NONE;
    case (addr[ADDR_W-1:MEM_AW])
      2'b00: begin
        if (addr[MEM_AW-1:8] == '0) begin
          case (addr[7:6])
            2'd0:    region = RG_CTRL;
            2'd1:    region = RG_STAT;
            2'd2:    region = RG_CQ;
            default: region = RG_CPL;
          endcase
        end
      end
      2'b01:   region = RG_IDEN;
      2'b10:   region = RG_CMEM;
      default: region = RG_NONE;
    endcase
  end
endmodule

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
#(
  parameter int PARAM_W = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [5:0]         word,
  input  logic [31:0]        wdata,
  output logic [PARAM_W-1:0] start_lba,
  output logic [PARAM_W-1:0] xfer_len,
  output logic [2:0]         patt_sel,
  output logic [31:0]        timeout_val,
  output logic               cmd_req,
  output logic [2:0]         cmd_code
);
  localparam int HI_W = PARAM_W - 32;

  logic [PARAM_W-1:0] lba_nxt, len_nxt;
  logic [2:0]         patt_nxt, code_nxt;
  logic [31:0]        tmo_nxt;
  logic               req_nxt;

  always_comb begin
    lba_nxt  = start_lba;
    len_nxt  = xfer_len;
    patt_nxt = patt_sel;
    tmo_nxt  = timeout_val;
    code_nxt = cmd_code;
    req_nxt  = 1'b0;
    if (wr_en) begin
      case (word)
        W_LBA_LO:  lba_nxt[31:0]         = wdata;
        W_LBA_HI:  lba_nxt[PARAM_W-1:32] = wdata[HI_W-1:0];
        W_LEN_LO:  len_nxt[31:0]         = wdata;
        W_LEN_HI:  len_nxt[PARAM_W-1:32] = wdata[HI_W-1:0];
        W_PATT:    patt_nxt              = wdata[2:0];
        W_TIMEOUT: tmo_nxt               = wdata;
        W_CMD: begin
          if (cmd_is_legal(wdata[2:0])) begin
            code_nxt = wdata[2:0];
            req_nxt  = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_lba   <= '0;
      xfer_len    <= '0;
      patt_sel    <= '0;
      timeout_val <= '0;
      cmd_code    <= '0;
      cmd_req     <= 1'b0;
    end else begin
      cmd_req <= req_nxt;
      if (wr_en) begin
        start_lba   <= lba_nxt;
        xfer_len    <= len_nxt;
        patt_sel    <= patt_nxt;
        timeout_val <= tmo_nxt;
        cmd_code    <= code_nxt;
      end
    end
  end

  // R4
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |-> cmd_is_legal(cmd_code));

  // R3
  req_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |-> ($past(wr_en) && $past(word) == W_CMD));
endmodule

// File: rtl/regbank_cq.sv
module regbank_cq #(
  parameter int NUM_DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [5:0]        word,
  input  logic [31:0]       wdata,
  output logic [NUM_DW*32-1:0] entry
);
  for (genvar i = 0; i < NUM_DW; i++) begin : g_dw
    logic        hit;
    logic [31:0] dw_q;
    assign hit = wr_en && (word == 6'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   dw_q <= '0;
      else if (hit) dw_q <= wdata;
    end
    assign entry[i*32 +: 32] = dw_q;
  end
endmodule

// File: rtl/regbank_rdmux.sv
module regbank_rdmux
  import regbank_pkg::*;
#(
  parameter int NUM_CPL = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_req,
  input  region_e              region,
  input  logic [5:0]           word,
  input  logic                 sts_busy,
  input  logic                 sts_error,
  input  logic                 sts_verify_fail,
  input  logic [NUM_CPL*32-1:0] cpl_dwords,
  input  logic [31:0]          idm_rd_data,
  input  logic [31:0]          cm_rd_data,
  output logic                 rd_valid,
  output logic [31:0]          rd_data
);
  localparam int CPL_IW = $clog2(NUM_CPL);

  logic [31:0] local_nxt, s1_local, out_nxt;
  region_e     s1_region;
  logic        s1_vld;

  // stage 1: word select inside the small register regions
  always_comb begin
    local_nxt = '0;
    case (region)
      RG_STAT: if (word == '0) local_nxt = {29'd0, sts_verify_fail, sts_error, sts_busy};
      RG_CPL:  if (32'(word) < NUM_CPL) local_nxt = cpl_dwords[word[CPL_IW-1:0]*32 +: 32];
      default: local_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld    <= 1'b0;
      s1_region <= RG_NONE;
      s1_local  <= '0;
    end else begin
      s1_vld <= rd_req;
      if (rd_req) begin
        s1_region <= region;
        s1_local  <= local_nxt;
      end
    end
  end

  // stage 2: region select
  always_comb begin
    case (s1_region)
      RG_IDEN: out_nxt = idm_rd_data;
      RG_CMEM: out_nxt = cm_rd_data;
      default: out_nxt = s1_local;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= s1_vld;
      if (s1_vld) rd_data <= out_nxt;
    end
  end

  // R12
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && (s1_region == RG_CTRL || s1_region == RG_CQ || s1_region == RG_NONE))
      |-> rd_data == '0);
endmodule

// File: rtl/regbank_be_expand.sv
module regbank_be_expand #(
  parameter int NUM_DW = 8
) (
  input  logic [NUM_DW-1:0]   dw_en,
  output logic [NUM_DW*4-1:0] byte_en
);
  for (genvar i = 0; i < NUM_DW; i++) begin : g_lane
    assign byte_en[i*4 +: 4] = {4{dw_en[i]}};
  end

  always_comb begin
    // R13
    be_count_chk: assert ($countones(byte_en) == 4 * $countones(dw_en));
  end
endmodule

// File: rtl/tst_regbank.sv
module tst_regbank
  import regbank_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int PARAM_W = 48,
  parameter int NUM_CQ  = 16,
  parameter int NUM_CPL = 4,
  parameter int DP_DW   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr_en,
  input  logic                  reg_rd_req,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [31:0]           reg_wr_data,
  input  logic [3:0]            reg_wr_be,
  output logic                  reg_rd_valid,
  output logic [31:0]           reg_rd_data,
  output logic                  cmd_req,
  output logic [2:0]            cmd_code,
  output logic [PARAM_W-1:0]    start_lba,
  output logic [PARAM_W-1:0]    xfer_len,
  output logic [2:0]            patt_sel,
  output logic [31:0]           timeout_val,
  input  logic                  sts_busy,
  input  logic                  sts_error,
  input  logic                  sts_verify_fail,
  output logic [NUM_CQ*32-1:0]  cq_dwords,
  input  logic [NUM_CPL*32-1:0] cpl_dwords,
  output logic [ADDR_W-3:0]     mem_addr,
  output logic                  idm_rd_en,
  input  logic [31:0]           idm_rd_data,
  output logic                  cm_rd_en,
  output logic                  cm_wr_en,
  output logic [31:0]           cm_wr_data,
  input  logic [31:0]           cm_rd_data,
  input  logic [DP_DW-1:0]      dp_dw_en,
  output logic [DP_DW*4-1:0]    dp_byte_en
);
  localparam int MEM_AW = ADDR_W - 2;

  region_e    region;
  logic [5:0] word;
  logic       be_any;

  assign word   = reg_addr[5:0];
  assign be_any = |reg_wr_be;

  regbank_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr   (reg_addr),
    .region (region)
  );

  regbank_ctrl #(.PARAM_W(PARAM_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (reg_wr_en && region == RG_CTRL),
    .word        (word),
    .wdata       (reg_wr_data),
    .start_lba   (start_lba),
    .xfer_len    (xfer_len),
    .patt_sel    (patt_sel),
    .timeout_val (timeout_val),
    .cmd_req     (cmd_req),
    .cmd_code    (cmd_code)
  );

  regbank_cq #(.NUM_DW(NUM_CQ)) u_cq (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr_en && region == RG_CQ),
    .word  (word),
    .wdata (reg_wr_data),
    .entry (cq_dwords)
  );

  regbank_rdmux #(.NUM_CPL(NUM_CPL)) u_rdmux (
    .clk             (clk),
    .rst_n           (rst_n),
    .rd_req          (reg_rd_req),
    .region          (region),
    .word            (word),
    .sts_busy        (sts_busy),
    .sts_error       (sts_error),
    .sts_verify_fail (sts_verify_fail),
    .cpl_dwords      (cpl_dwords),
    .idm_rd_data     (idm_rd_data),
    .cm_rd_data      (cm_rd_data),
    .rd_valid        (reg_rd_valid),
    .rd_data         (reg_rd_data)
  );

  regbank_be_expand #(.NUM_DW(DP_DW)) u_be (
    .dw_en   (dp_dw_en),
    .byte_en (dp_byte_en)
  );

  assign mem_addr   = reg_addr[MEM_AW-1:0];
  assign idm_rd_en  = reg_rd_req && region == RG_IDEN;
  assign cm_rd_en   = reg_rd_req && region == RG_CMEM;
  assign cm_wr_en   = reg_wr_en  && region == RG_CMEM;
  assign cm_wr_data = reg_wr_data;

  // R9
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_req |=> ##1 reg_rd_valid);

  // R11
  be_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !be_any && reg_addr[ADDR_W-1:MEM_AW] == 2'b10) |-> cm_wr_en);

  // R12
  ro_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && (region == RG_STAT || region == RG_CPL || region == RG_IDEN))
      |=> (!cmd_req && $stable(start_lba) && $stable(cq_dwords)));
endmodule

// File: tb/tst_regbank_test.sv
module tst_regbank_test;
  localparam int CLK_PER = 10;
  localparam int WDOG    = 20000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_wr_en, reg_rd_req;
  logic [12:0]  reg_addr;
  logic [31:0]  reg_wr_data;
  logic [3:0]   reg_wr_be;
  logic         reg_rd_valid;
  logic [31:0]  reg_rd_data;
  logic         cmd_req;
  logic [2:0]   cmd_code, patt_sel;
  logic [47:0]  start_lba, xfer_len;
  logic [31:0]  timeout_val;
  logic         sts_busy, sts_error, sts_verify_fail;
  logic [511:0] cq_dwords;
  logic [127:0] cpl_dwords;
  logic [10:0]  mem_addr;
  logic         idm_rd_en, cm_rd_en, cm_wr_en;
  logic [31:0]  idm_rd_data, cm_wr_data, cm_rd_data;
  logic [7:0]   dp_dw_en;
  logic [31:0]  dp_byte_en;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PER/2) clk = ~clk;

  tst_regbank uut (.*);

  // external memory models, one-cycle read latency
  logic [31:0] cmem [0:2047];
  always_ff @(posedge clk) begin
    if (idm_rd_en) idm_rd_data <= 32'h1D00_0000 | 32'(mem_addr);
    if (cm_rd_en)  cm_rd_data  <= cmem[mem_addr];
    if (cm_wr_en)  cmem[mem_addr] <= cm_wr_data;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected read data as read-valid appears
  always @(negedge clk) begin
    if (rst_n && reg_rd_valid) begin
      if (exp_q.size() == 0) check("R9 unexpected valid", 1, 0);
      else check(tag_q.pop_front(), reg_rd_data, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [15:0] byte_addr, input logic [31:0] d, input logic [3:0] be = 4'hF);
    reg_wr_en = 1'b1; reg_addr = byte_addr[14:2]; reg_wr_data = d; reg_wr_be = be;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  // driver: issues read and pushes expected value to scoreboard
  task automatic rd(input logic [15:0] byte_addr, input logic [31:0] exp, input string req);
    reg_rd_req = 1'b1; reg_addr = byte_addr[14:2];
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    reg_rd_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WDOG) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<%0d", cyc, WDOG);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] exp_be;
    reg_wr_en = 0; reg_rd_req = 0; reg_addr = '0; reg_wr_data = '0; reg_wr_be = 4'hF;
    sts_busy = 0; sts_error = 0; sts_verify_fail = 0; dp_dw_en = '0;
    cpl_dwords = {32'hC0DE_0003, 32'hC0DE_0002, 32'hC0DE_0001, 32'hC0DE_0000};
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset cmd_req", cmd_req, 0);
    check("R1 reset rd_valid", reg_rd_valid, 0);
    check("R1 reset params", {start_lba, xfer_len}, 0);
    check("R1 reset timeout/patt", {timeout_val, patt_sel}, 0);
    check("R1 reset cq", |cq_dwords, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 + R11 (zero byte enables)
    wr(16'h0000, 32'hDEAD_BEEF, 4'h0);
    wr(16'h0004, 32'hFFFF_1234, 4'h1);
    wr(16'h0008, 32'h0000_0100);
    wr(16'h000C, 32'h0000_00AB);
    check("R2/R11 start_lba", start_lba, 48'h1234_DEAD_BEEF);
    check("R2 xfer_len", xfer_len, 48'h00AB_0000_0100);

    // R5
    wr(16'h0014, 32'hFFFF_FFFC);
    wr(16'h0020, 32'h1357_9BDF);
    check("R5 patt_sel", patt_sel, 3'b100);
    check("R5 timeout", timeout_val, 32'h1357_9BDF);

    // R3: pulse visible right after the write cycle, then gone
    wr(16'h0010, 32'h0000_0003);
    check("R3 cmd_req high", cmd_req, 1);
    check("R3 cmd_code", cmd_code, 3'b011);
    @(negedge clk);
    check("R3 cmd_req one cycle", cmd_req, 0);
    wr(16'h0010, 32'h0000_0006);
    check("R3 flush code", {cmd_req, cmd_code}, {1'b1, 3'b110});
    @(negedge clk);

    // R4
    wr(16'h0010, 32'h0000_0005);
    check("R4 reserved 101 no req", cmd_req, 0);
    wr(16'h0010, 32'h0000_0007);
    check("R4 reserved 111 no req", cmd_req, 0);
    check("R4 code kept", cmd_code, 3'b110);

    // R7
    for (int k = 0; k < 16; k++) wr(16'h0200 + 16'(4*k), 32'hA000_0000 + 32'(k));
    check("R7 cq dw0", cq_dwords[31:0], 32'hA000_0000);
    check("R7 cq dw15", cq_dwords[511:480], 32'hA000_000F);

    // R6, R8, R9
    sts_busy = 1; sts_verify_fail = 1;
    rd(16'h0100, 32'h5, "R6 status busy+vfail");
    sts_busy = 0; sts_error = 1; sts_verify_fail = 0;
    rd(16'h0100, 32'h2, "R6 status error");
    rd(16'h0104, 32'h0, "R6 status other word zero");
    rd(16'h0300, 32'hC0DE_0000, "R8 cpl dw0");
    rd(16'h030C, 32'hC0DE_0003, "R8 cpl dw3");
    rd(16'h0310, 32'h0, "R8 cpl beyond");

    // R12
    rd(16'h0000, 32'h0, "R12 control read zero");
    rd(16'h0204, 32'h0, "R12 cq read zero");
    rd(16'h0400, 32'h0, "R12 gap read zero");
    rd(16'h7000, 32'h0, "R12 unmapped read zero");
    wr(16'h0110, 32'h0000_0002);
    check("R12 status write no req", cmd_req, 0);
    wr(16'h0300, 32'hFFFF_FFFF);
    wr(16'h2000, 32'hFFFF_FFFF);
    check("R12 ro writes keep lba", start_lba, 48'h1234_DEAD_BEEF);
    check("R12 ro writes keep cq", cq_dwords[31:0], 32'hA000_0000);

    // R10
    rd(16'h2000, 32'h1D00_0000, "R10 identify word 0");
    rd(16'h3FFC, 32'h1D00_07FF, "R10 identify last word");
    wr(16'h4008, 32'hCAFE_0002, 4'h0);
    wr(16'h5FFC, 32'hCAFE_07FF);
    rd(16'h4008, 32'hCAFE_0002, "R10/R11 custom mem word 2");
    rd(16'h5FFC, 32'hCAFE_07FF, "R10 custom mem last word");

    // overlap: status read, then command write the next cycle (R3 + R9)
    sts_busy = 1; sts_error = 0;
    reg_rd_req = 1; reg_addr = 13'h040;
    exp_q.push_back(32'h1); tag_q.push_back("R9 read under command write");
    @(negedge clk);
    reg_rd_req = 0; sts_busy = 0;
    wr(16'h0010, 32'h0000_0002);
    check("R3 pulse coincides with valid", {cmd_req, reg_rd_valid, cmd_code}, {1'b1, 1'b1, 3'b010});
    @(negedge clk);

    // overlap: custom read then write the same word (R10)
    reg_rd_req = 1; reg_addr = 13'h1002;
    exp_q.push_back(32'hCAFE_0002); tag_q.push_back("R10 read before overwrite");
    @(negedge clk);
    reg_rd_req = 0;
    wr(16'h4008, 32'h0BAD_0002);
    @(negedge clk);
    rd(16'h4008, 32'h0BAD_0002, "R10 overwrite landed");

    // R13
    for (int p = 0; p < 3; p++) begin
      dp_dw_en = (p == 0) ? 8'h85 : (p == 1) ? 8'hFF : 8'h00;
      exp_be = '0;
      for (int i = 0; i < 8; i++) if (dp_dw_en[i]) exp_be[i*4 +: 4] = 4'hF;
      #1;
      check("R13 byte enable expansion", dp_byte_en, exp_be);
    end

    repeat (3) @(negedge clk);
    check("R9 all reads returned", exp_q.size(), 0);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule